// File: doc/BRIEF.md
# Raster Line and Dot Interrupt Generator

This block watches the raster position coming from a display timing counter and raises short interrupt pulses when that position reaches a programmed target. It has three channels. Two channels fire on a programmed line at dot zero, and both targets are loaded by one 32-bit register write. The third channel fires on a programmed line and dot. That channel has a repeat setting: it can fire once per frame, once every N lines, or on every line.

Targets are given in field lines. In interlaced scan, a target of field line L matches raster line 2L during the even field and raster line 2L+1 during the odd field. In progressive scan it matches raster line L. A target whose mapped raster line is not below the total line count is disabled and never fires. In the repeating modes the next target is moved forward by the step after each firing. The sum wraps against half the total line count.

The raster counter and the interrupt controller are outside this block. Each output is a one-cycle pulse that a downstream controller can latch.

Top module: `scanirq_gen`

## Requirements
- R1: A write with `vpos_wr_en` high loads the first target line from `vpos_wr_data[25:16]` and the second from `vpos_wr_data[9:0]`. All other data bits are ignored. The new targets apply from the next cycle. The first target drives `irq_vpos1` and the second drives `irq_vpos2`. Both channels compare against dot 0.
- R2: When `interlaced` is 0, a target of field line L matches raster line L.
- R3: When `interlaced` is 1, a target of field line L matches raster line 2L while `odd_field` is 0, and raster line 2L+1 while `odd_field` is 1.
- R4: A channel whose mapped raster line is greater than or equal to `total_lines` never pulses.
- R5: A write with `hpos_wr_en` high takes the line/step field from `hpos_wr_data[9:0]`, the mode from `hpos_wr_data[13:12]` and the dot from `hpos_wr_data[25:16]`. All other bits are ignored, and the new setting applies from the next cycle.
- R6: Mode 0 and mode 3 give a fixed target: `irq_hpos` fires each time the raster reaches the mapped line and the target dot.
- R7: Mode 1 uses the line field as a step N, with N no larger than half of `total_lines`. At the write, the target becomes (`raster_line` >> 1) + N. Each time `irq_hpos` fires, the target becomes target + N. In both cases a result greater than `total_lines`/2 has `total_lines`/2 subtracted from it.
- R8: Mode 2 behaves exactly as mode 1 with N = 1, whatever the line field holds.
- R9: The dot that `irq_hpos` compares against is the programmed dot, clamped to `line_last_dot` when it is larger.
- R10: An interrupt output goes high for exactly one cycle, in the cycle after the matching position is presented. A matching position that is held for several cycles gives a single pulse.
- R11: After reset, all three outputs are low and every target register is zero: both vertical targets are line 0, and the line/dot channel is in mode 0 at line 0, dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| raster_line | input | 10 | Current raster line from the timing counter |
| raster_dot | input | 10 | Current dot within the line |
| odd_field | input | 1 | High during the odd field |
| interlaced | input | 1 | Interlaced scan enable |
| total_lines | input | 11 | Number of raster lines per frame |
| line_last_dot | input | 10 | Index of the last dot of a line |
| vpos_wr_en | input | 1 | Write strobe for the two vertical targets |
| vpos_wr_data | input | 32 | Write data for the vertical targets |
| hpos_wr_en | input | 1 | Write strobe for the line/dot channel |
| hpos_wr_data | input | 32 | Write data for the line/dot channel |
| irq_vpos1 | output | 1 | Pulse from the first vertical target |
| irq_vpos2 | output | 1 | Pulse from the second vertical target |
| irq_hpos | output | 1 | Pulse from the line/dot channel |

## Verification
The assertions rely on a legal raster input: the line stays below `total_lines`, the dot stays at or below `line_last_dot`, and `odd_field` changes only at a frame boundary. They also assume that a repeat step never exceeds half the frame lines. The bench meets these conditions by driving the raster from its own counter. That counter either advances one dot per cycle or holds on purpose, and it wraps lines and toggles the field only at the frame end. Every repeat step the bench programs is chosen within that half-frame limit.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;
  localparam int FIELD_W      = 10;
  localparam int TGT_A_LSB    = 16;
  localparam int TGT_B_LSB    = 0;
  localparam int HP_LINE_LSB  = 0;
  localparam int HP_MODE_LSB  = 12;
  localparam int HP_DOT_LSB   = 16;
  localparam int NUM_CH       = 3;
  localparam int CH_V1        = 0;
  localparam int CH_V2        = 1;
  localparam int CH_H         = 2;

  typedef enum logic [1:0] {
    HM_ONCE       = 2'd0,
    HM_EVERY_N    = 2'd1,
    HM_EVERY_LINE = 2'd2,
    HM_RSVD       = 2'd3
  } hmode_e;
endpackage

// File: rtl/scanirq_line_match.sv
module scanirq_line_match #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic [LINE_W-1:0] tgt_line,
  input  logic [DOT_W-1:0]  tgt_dot,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [DOT_W-1:0]  raster_dot,
  input  logic              odd_field,
  input  logic              interlaced,
  input  logic [LINE_W:0]   total_lines,
  output logic              hit
);
  logic [LINE_W:0] mapped;

  // Field line to raster line: 2L + parity under interlace, L otherwise
  assign mapped = interlaced ? {tgt_line, odd_field} : {1'b0, tgt_line};

  assign hit = (mapped < total_lines) &&
               (mapped == {1'b0, raster_line}) &&
               (raster_dot == tgt_dot);
endmodule

// File: rtl/scanirq_pulse.sv
module scanirq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic rise,
  output logic irq
);
  logic hit_q;
  logic irq_q;

  assign rise = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hit_q <= hit;
      irq_q <= rise;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/scanirq_hpos_ctrl.sv
module scanirq_hpos_ctrl
  import scanirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              fire,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [LINE_W:0]   total_lines,
  input  logic [DOT_W-1:0]  line_last_dot,
  output logic [LINE_W-1:0] tgt_line,
  output logic [DOT_W-1:0]  tgt_dot
);
  localparam int SUM_W = LINE_W + 1;

  logic [LINE_W-1:0] line_q, line_d;
  logic [LINE_W-1:0] step_q, step_d;
  logic [DOT_W-1:0]  dot_q, dot_d;
  logic              rpt_q, rpt_d;
  logic              upd_en;
  hmode_e            wr_mode;
  logic [LINE_W-1:0] wr_field;
  logic [LINE_W-1:0] wr_step;
  logic [SUM_W-1:0]  half_frame;
  logic [SUM_W-1:0]  start_sum;
  logic [SUM_W-1:0]  next_sum;

  function automatic logic [LINE_W-1:0] wrap_half(input logic [SUM_W-1:0] s,
                                                  input logic [SUM_W-1:0] h);
    logic [SUM_W-1:0] r;
    r = (s > h) ? (s - h) : s;
    return r[LINE_W-1:0];
  endfunction

  assign wr_mode    = hmode_e'(wr_data[HP_MODE_LSB +: 2]);
  assign wr_field   = wr_data[HP_LINE_LSB +: LINE_W];
  assign wr_step    = (wr_mode == HM_EVERY_LINE) ? LINE_W'(1) : wr_field;
  assign half_frame = {1'b0, total_lines[LINE_W:1]};
  assign start_sum  = {2'b00, raster_line[LINE_W-1:1]} + {1'b0, wr_step};
  assign next_sum   = {1'b0, line_q} + {1'b0, step_q};
  assign upd_en     = wr_en || (fire && rpt_q);

  always_comb begin
    line_d = line_q;
    step_d = step_q;
    dot_d  = dot_q;
    rpt_d  = rpt_q;
    if (wr_en) begin
      dot_d = wr_data[HP_DOT_LSB +: DOT_W];
      case (wr_mode)
        HM_EVERY_N, HM_EVERY_LINE: begin
          step_d = wr_step;
          line_d = wrap_half(start_sum, half_frame);
          rpt_d  = 1'b1;
        end
        default: begin
          line_d = wr_field;
          rpt_d  = 1'b0;
        end
      endcase
    end else if (fire && rpt_q) begin
      line_d = wrap_half(next_sum, half_frame);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      step_q <= '0;
      dot_q  <= '0;
      rpt_q  <= 1'b0;
    end else if (upd_en) begin
      line_q <= line_d;
      step_q <= step_d;
      dot_q  <= dot_d;
      rpt_q  <= rpt_d;
    end
  end

  assign tgt_line = line_q;
  assign tgt_dot  = (dot_q > line_last_dot) ? line_last_dot : dot_q;
endmodule

// File: rtl/scanirq_gen.sv
module scanirq_gen
  import scanirq_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [DOT_W-1:0]  raster_dot,
  input  logic              odd_field,
  input  logic              interlaced,
  input  logic [LINE_W:0]   total_lines,
  input  logic [DOT_W-1:0]  line_last_dot,
  input  logic              vpos_wr_en,
  input  logic [31:0]       vpos_wr_data,
  input  logic              hpos_wr_en,
  input  logic [31:0]       hpos_wr_data,
  output logic              irq_vpos1,
  output logic              irq_vpos2,
  output logic              irq_hpos
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [LINE_W-1:0] v1_q, v2_q;
  logic [LINE_W-1:0] h_line;
  logic [DOT_W-1:0]  h_dot;
  logic [LINE_W-1:0] ch_line [NUM_CH];
  logic [DOT_W-1:0]  ch_dot  [NUM_CH];
  logic [NUM_CH-1:0] ch_hit, ch_rise, ch_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      v1_q <= '0;
      v2_q <= '0;
    end else if (vpos_wr_en) begin
      v1_q <= vpos_wr_data[TGT_A_LSB +: LINE_W];
      v2_q <= vpos_wr_data[TGT_B_LSB +: LINE_W];
    end
  end

  scanirq_hpos_ctrl #(.LINE_W(LINE_W), .DOT_W(DOT_W)) hpos_ctrl_i (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .wr_en         (hpos_wr_en),
    .wr_data       (hpos_wr_data),
    .fire          (ch_rise[CH_H]),
    .raster_line   (raster_line),
    .total_lines   (total_lines),
    .line_last_dot (line_last_dot),
    .tgt_line      (h_line),
    .tgt_dot       (h_dot)
  );

  assign ch_line[CH_V1] = v1_q;
  assign ch_dot[CH_V1]  = '0;
  assign ch_line[CH_V2] = v2_q;
  assign ch_dot[CH_V2]  = '0;
  assign ch_line[CH_H]  = h_line;
  assign ch_dot[CH_H]   = h_dot;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    scanirq_line_match #(.LINE_W(LINE_W), .DOT_W(DOT_W)) match_i (
      .tgt_line    (ch_line[g]),
      .tgt_dot     (ch_dot[g]),
      .raster_line (raster_line),
      .raster_dot  (raster_dot),
      .odd_field   (odd_field),
      .interlaced  (interlaced),
      .total_lines (total_lines),
      .hit         (ch_hit[g])
    );
    scanirq_pulse pulse_i (
      .clk   (clk),
      .rst_n (core_rst_n),
      .hit   (ch_hit[g]),
      .rise  (ch_rise[g]),
      .irq   (ch_irq[g])
    );
  end

  assign irq_vpos1 = ch_irq[CH_V1];
  assign irq_vpos2 = ch_irq[CH_V2];
  assign irq_hpos  = ch_irq[CH_H];
endmodule

// File: rtl/scanirq_gen_chk.sv
module scanirq_gen_chk #(
  parameter int LINE_W = 10,
  parameter int DOT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] raster_line,
  input logic [DOT_W-1:0]  raster_dot,
  input logic              odd_field,
  input logic              interlaced,
  input logic [LINE_W:0]   total_lines,
  input logic [DOT_W-1:0]  line_last_dot,
  input logic              irq_vpos1,
  input logic              irq_vpos2,
  input logic              irq_hpos
);
  AST_V1_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vpos1 |=> !irq_vpos1); // R10
  AST_V2_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vpos2 |=> !irq_vpos2); // R10
  AST_H_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos |=> !irq_hpos); // R10
  AST_V1_AT_DOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vpos1 |-> $past(raster_dot) == '0); // R1
  AST_V2_AT_DOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vpos2 |-> $past(raster_dot) == '0); // R1
  AST_V1_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vpos1 |-> {1'b0, $past(raster_line)} < $past(total_lines)); // R4
  AST_H_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos |-> {1'b0, $past(raster_line)} < $past(total_lines)); // R4
  AST_H_DOT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hpos |-> $past(raster_dot) <= $past(line_last_dot)); // R9
  AST_V1_FIELD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vpos1 && $past(interlaced)) |-> $past(raster_line[0]) == $past(odd_field)); // R3
  AST_V2_FIELD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vpos2 && $past(interlaced)) |-> $past(raster_line[0]) == $past(odd_field)); // R3
endmodule

bind scanirq_gen scanirq_gen_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .raster_line   (raster_line),
  .raster_dot    (raster_dot),
  .odd_field     (odd_field),
  .interlaced    (interlaced),
  .total_lines   (total_lines),
  .line_last_dot (line_last_dot),
  .irq_vpos1     (irq_vpos1),
  .irq_vpos2     (irq_vpos2),
  .irq_hpos      (irq_hpos)
);

// File: tb/scanirq_gen_tb_top.sv
module scanirq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  raster_line;
  logic [9:0]  raster_dot;
  logic        odd_field;
  logic        interlaced;
  logic [10:0] total_lines;
  logic [9:0]  line_last_dot;
  logic        vpos_wr_en;
  logic [31:0] vpos_wr_data;
  logic        hpos_wr_en;
  logic [31:0] hpos_wr_data;
  logic        irq_vpos1, irq_vpos2, irq_hpos;

  always #10 clk = ~clk;

  scanirq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .raster_line(raster_line), .raster_dot(raster_dot),
    .odd_field(odd_field), .interlaced(interlaced), .total_lines(total_lines),
    .line_last_dot(line_last_dot), .vpos_wr_en(vpos_wr_en), .vpos_wr_data(vpos_wr_data),
    .hpos_wr_en(hpos_wr_en), .hpos_wr_data(hpos_wr_data),
    .irq_vpos1(irq_vpos1), .irq_vpos2(irq_vpos2), .irq_hpos(irq_hpos)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string ph  = "R11";

  // reference model state
  int m_v1, m_v2, m_hl, m_hs, m_hd, m_rpt;
  int m_prev [3];
  bit exp_q [3];
  int m_wait;
  int cnt_v2, cnt_h;

  // bench raster counter
  int r_line, r_dot, r_odd, r_int, r_tot, r_last;

  function automatic int map_line(int l);
    return r_int ? (2 * l + r_odd) : l;
  endfunction

  function automatic int wrap_half(int s);
    int h = r_tot / 2;
    return (s > h) ? s - h : s;
  endfunction

  function automatic bit hits(int l, int d);
    int m = map_line(l);
    return (m < r_tot) && (m == r_line) && (r_dot == d);
  endfunction

  task automatic check(input bit got, input bit expv, input string what);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b line=%0d dot=%0d", ph, what, got, expv, r_line, r_dot);
    end
  endtask

  task automatic model_reset();
    m_v1 = 0; m_v2 = 0; m_hl = 0; m_hs = 0; m_hd = 0; m_rpt = 0;
    for (int i = 0; i < 3; i++) begin m_prev[i] = 0; exp_q[i] = 0; end
    m_wait = 2;
  endtask

  task automatic drive_raster();
    raster_line = r_line[9:0]; raster_dot = r_dot[9:0]; odd_field = r_odd[0];
    interlaced = r_int[0]; total_lines = r_tot[10:0]; line_last_dot = r_last[9:0];
  endtask

  task automatic advance();
    if (r_dot >= r_last) begin
      r_dot = 0;
      if (r_line >= r_tot - 1) begin
        r_line = 0;
        if (r_int != 0) r_odd = 1 - r_odd;
      end else r_line++;
    end else r_dot++;
  endtask

  // one clock: check outputs of the previous edge, drive new inputs, predict next edge
  task automatic step(input bit hold, input bit vw, input int vd, input bit hw, input int hd);
    bit hm [3];
    int hdot, mode, n;
    @(negedge clk);
    check(irq_vpos1, exp_q[0], "irq_vpos1");
    check(irq_vpos2, exp_q[1], "irq_vpos2");
    check(irq_hpos,  exp_q[2], "irq_hpos");
    if (irq_vpos2) cnt_v2++;
    if (irq_hpos)  cnt_h++;
    if (!hold) advance();
    drive_raster();
    vpos_wr_en = vw; vpos_wr_data = vd;
    hpos_wr_en = hw; hpos_wr_data = hd;
    if (m_wait > 0) begin
      m_wait--;
      for (int i = 0; i < 3; i++) exp_q[i] = 0;
      return;
    end
    hdot = (m_hd > r_last) ? r_last : m_hd;
    hm[0] = hits(m_v1, 0);
    hm[1] = hits(m_v2, 0);
    hm[2] = hits(m_hl, hdot);
    for (int i = 0; i < 3; i++) begin
      exp_q[i] = hm[i] && !m_prev[i];
      m_prev[i] = hm[i];
    end
    if (vw) begin m_v1 = (vd >> 16) & 1023; m_v2 = vd & 1023; end
    if (hw) begin
      mode = (hd >> 12) & 3;
      m_hd = (hd >> 16) & 1023;
      if (mode == 1 || mode == 2) begin
        n = (mode == 2) ? 1 : (hd & 1023);
        m_hs = n;
        m_hl = wrap_half(r_line / 2 + n);
        m_rpt = 1;
      end else begin
        m_hl = hd & 1023;
        m_rpt = 0;
      end
    end else if (exp_q[2] && m_rpt != 0) begin
      m_hl = wrap_half(m_hl + m_hs);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    r_line = 0; r_dot = 0; r_odd = 0; r_int = 0; r_tot = 20; r_last = 7;
    drive_raster();
    vpos_wr_en = 0; vpos_wr_data = 0; hpos_wr_en = 0; hpos_wr_data = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs low while in reset
    check(irq_vpos1, 0, "reset irq_vpos1");
    check(irq_vpos2, 0, "reset irq_vpos2");
    check(irq_hpos,  0, "reset irq_hpos");
    rst_n = 1;
    // R11: reset targets are line 0 / dot 0 in mode 0, so frame start pulses all three
    run(200);

    // R1, R2: masked vpos write, progressive
    ph = "R1"; step(0, 1, 32'hFC03FC06, 0, 0);
    ph = "R2"; run(340);

    // R10: hold a matching position for several cycles
    ph = "R10";
    while (!(r_line == 2 && r_dot == 7)) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    run(20);

    // R3: interlaced mapping, odd total line count
    ph = "R3"; r_int = 1; r_tot = 21; r_line = 0; r_dot = 0; r_odd = 0;
    step(1, 1, 32'h00040002, 0, 0);
    run(21 * 8 * 3);

    // R4: target maps beyond the frame, second channel must stay silent
    ph = "R4"; cnt_v2 = 0;
    step(0, 1, 32'h0004000F, 0, 0);
    run(21 * 8 * 3);
    checks++;
    if (cnt_v2 != 0) begin fails++; $display("FAIL R4 vpos2 pulses actual=%0d expected=0", cnt_v2); end

    // R5, R6: mode 0 with junk bits, progressive
    ph = "R5"; r_int = 0; r_tot = 20; r_odd = 0; cnt_h = 0;
    step(0, 0, 0, 1, 32'hFC03C005 & 32'hFFFFCFFF);
    ph = "R6"; run(20 * 8 * 3);
    // R6: mode 3 behaves as mode 0
    step(0, 0, 0, 1, 32'h00023004);
    run(20 * 8 * 2);

    // R9: dot above line length clamps to last dot
    ph = "R9"; step(0, 0, 0, 1, 32'h001E0006);
    run(20 * 8 * 2);

    // R7: every N lines, wrap against half frame
    ph = "R7"; step(0, 0, 0, 1, 32'h00021003);
    run(20 * 8 * 4);
    // R7 under interlace
    r_int = 1; r_tot = 21;
    step(0, 0, 0, 1, 32'h00011004);
    run(21 * 8 * 4);

    // R8: every line, line field ignored
    ph = "R8"; r_int = 0; r_tot = 20; r_odd = 0; cnt_h = 0;
    step(0, 0, 0, 1, 32'h00032009);
    run(20 * 8 * 3);
    checks++;
    if (cnt_h < 20) begin fails++; $display("FAIL R8 hpos pulses actual=%0d expected>=20", cnt_h); end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule